// File: doc/BRIEF.md
# Power-Down Sequencer with Wake Qualification

This block turns a software power-down request into a halted core and then waits for the one kind of event that the chosen sleep level accepts. The register decoder passes the 6-bit request code to the block with a one-cycle write strobe. That code sits in bits 15:10 of the processor control word. Legal codes select one of three sleep levels. In the shallowest level, the code also chooses whether only an enabled interrupt can end the sleep, or any pending interrupt can.

While the core sleeps, the block holds a halt output high and reports the active level on a small output. When a qualifying interrupt arrives, the block returns to normal operation on the next clock and gives a one-cycle wake strobe. The two deeper levels ignore interrupts, and only a device reset ends them. A device reset brings the block back to normal operation from any level.

The request field is write-only. On the control-word read path, the block passes every other bit through and forces the six field bits to zero.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, the block is in normal operation: `pd_level_o`=0, `cpu_halt_o`=0 and `wake_pulse_o`=0.
- R2: While running, writing code 001001 makes `pd_level_o`=1 and `cpu_halt_o`=1 one clock edge after the write is sampled. This level wakes only on an enabled interrupt.
- R3: While running, writing code 010001 makes `pd_level_o`=1. In this mode, any pending interrupt line ends the sleep, whatever its enable mask.
- R4: While running, code 011010 gives `pd_level_o`=2 and code 011100 gives `pd_level_o`=3, each one clock edge after the write.
- R5: A write of 000000, or of any code not listed in R2 to R4, leaves the block running with `pd_level_o`=0.
- R6: `csr_rd_o` equals `csr_rd_i` with bits 15:10 forced to zero.
- R7: In either level-1 mode, a sampled interrupt that is both pending and enabled (`irq_pend_i & irq_en_mask_i` nonzero) returns the block to level 0 at the next edge. At that same edge `wake_pulse_o` goes high for exactly one cycle.
- R8: In the enabled-only level-1 mode (code 001001), a pending interrupt whose mask bit is clear has no effect.
- R9: At levels 2 and 3, interrupts have no effect. The level holds, and `wake_pulse_o` stays low, until a device reset arrives.
- R10: A sampled `dev_rst_i` returns the block to level 0 from any state at the next edge, with `wake_pulse_o`=0. It overrides a request write or an interrupt in the same cycle.
- R11: Request writes sampled while the level is not 0 are ignored.
- R12: `cpu_halt_o` is 1 exactly when `pd_level_o` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_rst_i | input | 1 | Device reset event, used as the wake source for the deep levels |
| req_we_i | input | 1 | Write strobe for the power-down request |
| req_code_i | input | 6 | Request code (control word bits 15:10) |
| csr_rd_i | input | WORD_W | Control word from the register file, before masking |
| csr_rd_o | output | WORD_W | Control word with the request field read as zero |
| irq_pend_i | input | NUM_IRQ | Raw pending interrupt lines |
| irq_en_mask_i | input | NUM_IRQ | Per-line interrupt enable |
| cpu_halt_o | output | 1 | Halts the CPU clock while sleeping |
| pd_level_o | output | 2 | Active sleep level: 0 running, 1, 2 or 3 |
| wake_pulse_o | output | 1 | One-cycle strobe on an interrupt wake |

## Verification
Several events can fall in the same cycle: a device reset together with a request write while running, and a device reset together with a qualifying interrupt while at level 1. The bench drives each pair on a single clock edge. It then expects level 0 with no wake strobe, because the reset takes precedence over both the new request and the interrupt wake. The bench also sweeps all 64 request codes. For each one it applies an unmasked raw interrupt, then an enabled interrupt, then a device reset, and compares each result against the level and wake source that the code selects.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  localparam int PD_CODE_W = 6;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_PD1_EN  = 3'd1,
    ST_PD1_ANY = 3'd2,
    ST_PD2     = 3'd3,
    ST_PD3     = 3'd4
  } pd_state_e;

  localparam logic [PD_CODE_W-1:0] CODE_PD1_EN  = 6'b001001;
  localparam logic [PD_CODE_W-1:0] CODE_PD1_ANY = 6'b010001;
  localparam logic [PD_CODE_W-1:0] CODE_PD2     = 6'b011010;
  localparam logic [PD_CODE_W-1:0] CODE_PD3     = 6'b011100;

  function automatic logic [1:0] level_of(pd_state_e s);
    logic [1:0] lv;
    case (s)
      ST_PD1_EN, ST_PD1_ANY: lv = 2'd1;
      ST_PD2:                lv = 2'd2;
      ST_PD3:                lv = 2'd3;
      default:               lv = 2'd0;
    endcase
    return lv;
  endfunction

endpackage

// File: rtl/pdc_code_decode.sv
module pdc_code_decode
  import pdc_pkg::*;
(
  input  logic [PD_CODE_W-1:0] code_i,
  output pd_state_e            target_o,
  output logic                 legal_o
);

  always_comb begin
    target_o = ST_RUN;
    legal_o  = 1'b1;
    case (code_i)
      CODE_PD1_EN:  target_o = ST_PD1_EN;
      CODE_PD1_ANY: target_o = ST_PD1_ANY;
      CODE_PD2:     target_o = ST_PD2;
      CODE_PD3:     target_o = ST_PD3;
      default:      legal_o  = 1'b0;
    endcase
  end

endmodule

// File: rtl/pdc_wake_eval.sv
module pdc_wake_eval #(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] mask_i,
  output logic               enabled_hit_o,
  output logic               any_hit_o
);

  logic [NUM_IRQ-1:0] qualified;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    assign qualified[g] = pend_i[g] & mask_i[g];
  end

  assign enabled_hit_o = |qualified;
  assign any_hit_o     = |pend_i;

endmodule

// File: rtl/pdc_csr_mask.sv
module pdc_csr_mask #(
  parameter int WORD_W    = 32,
  parameter int FIELD_LSB = 10,
  parameter int FIELD_W   = 6
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);

  localparam int FIELD_MSB = FIELD_LSB + FIELD_W - 1;

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    if (b >= FIELD_LSB && b <= FIELD_MSB) begin : g_hide
      assign word_o[b] = 1'b0 & word_i[b];
    end else begin : g_pass
      assign word_o[b] = word_i[b];
    end
  end

endmodule

// File: rtl/pdc_fsm.sv
module pdc_fsm
  import pdc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      dev_rst_i,
  input  logic      req_we_i,
  input  pd_state_e req_target_i,
  input  logic      req_legal_i,
  input  logic      enabled_hit_i,
  input  logic      any_hit_i,
  output logic      halt_o,
  output logic [1:0] level_o,
  output logic      wake_o
);

  pd_state_e state_q, state_d;
  logic      wake_d;

  always_comb begin
    state_d = state_q;
    wake_d  = 1'b0;
    if (dev_rst_i) begin
      state_d = ST_RUN;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (req_we_i && req_legal_i) state_d = req_target_i;
        end
        ST_PD1_EN: begin
          if (enabled_hit_i) begin
            state_d = ST_RUN;
            wake_d  = 1'b1;
          end
        end
        ST_PD1_ANY: begin
          if (any_hit_i) begin
            state_d = ST_RUN;
            wake_d  = 1'b1;
          end
        end
        ST_PD2, ST_PD3: state_d = state_q;
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      halt_o  <= 1'b0;
      level_o <= 2'd0;
      wake_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      halt_o  <= (state_d != ST_RUN);
      level_o <= level_of(state_d);
      wake_o  <= wake_d;
    end
  end

endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pdc_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int FIELD_LSB = 10,
  parameter int NUM_IRQ   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dev_rst_i,
  input  logic                 req_we_i,
  input  logic [PD_CODE_W-1:0] req_code_i,
  input  logic [WORD_W-1:0]    csr_rd_i,
  output logic [WORD_W-1:0]    csr_rd_o,
  input  logic [NUM_IRQ-1:0]   irq_pend_i,
  input  logic [NUM_IRQ-1:0]   irq_en_mask_i,
  output logic                 cpu_halt_o,
  output logic [1:0]           pd_level_o,
  output logic                 wake_pulse_o
);

  pd_state_e tgt;
  logic      tgt_legal;
  logic      en_hit;
  logic      any_hit;

  pdc_code_decode u_dec (
    .code_i   (req_code_i),
    .target_o (tgt),
    .legal_o  (tgt_legal)
  );

  pdc_wake_eval #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .pend_i        (irq_pend_i),
    .mask_i        (irq_en_mask_i),
    .enabled_hit_o (en_hit),
    .any_hit_o     (any_hit)
  );

  pdc_csr_mask #(
    .WORD_W    (WORD_W),
    .FIELD_LSB (FIELD_LSB),
    .FIELD_W   (PD_CODE_W)
  ) u_mask (
    .word_i (csr_rd_i),
    .word_o (csr_rd_o)
  );

  pdc_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .dev_rst_i     (dev_rst_i),
    .req_we_i      (req_we_i),
    .req_target_i  (tgt),
    .req_legal_i   (tgt_legal),
    .enabled_hit_i (en_hit),
    .any_hit_i     (any_hit),
    .halt_o        (cpu_halt_o),
    .level_o       (pd_level_o),
    .wake_o        (wake_pulse_o)
  );

endmodule

// File: rtl/pwrdn_ctrl_chk.sv
module pwrdn_ctrl_chk #(
  parameter int WORD_W    = 32,
  parameter int FIELD_LSB = 10,
  parameter int NUM_IRQ   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               dev_rst_i,
  input logic               req_we_i,
  input logic [5:0]         req_code_i,
  input logic [WORD_W-1:0]  csr_rd_i,
  input logic [WORD_W-1:0]  csr_rd_o,
  input logic [NUM_IRQ-1:0] irq_pend_i,
  input logic [NUM_IRQ-1:0] irq_en_mask_i,
  input logic               cpu_halt_o,
  input logic [1:0]         pd_level_o,
  input logic               wake_pulse_o
);

  localparam logic [WORD_W-1:0] FMASK = {{(WORD_W-6){1'b0}}, 6'h3F} << FIELD_LSB;

  logic code_known;
  assign code_known = (req_code_i == 6'b001001) || (req_code_i == 6'b010001) ||
                      (req_code_i == 6'b011010) || (req_code_i == 6'b011100);

  AST_HALT_TRACKS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    cpu_halt_o == (pd_level_o != 2'd0)); // R12

  AST_FIELD_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((csr_rd_o & FMASK) == '0) && ((csr_rd_o | FMASK) == (csr_rd_i | FMASK))); // R6

  AST_WAKE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wake_pulse_o |=> !wake_pulse_o); // R7

  AST_ENABLED_IRQ_WAKES: assert property (@(posedge clk) disable iff (rst)
    (pd_level_o == 2'd1 && !dev_rst_i && (|(irq_pend_i & irq_en_mask_i)))
      |=> (pd_level_o == 2'd0 && wake_pulse_o)); // R7

  AST_DEEP_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (pd_level_o >= 2'd2 && !dev_rst_i) |=> (pd_level_o == $past(pd_level_o) && !wake_pulse_o)); // R9

  AST_DEVRST_TO_RUN: assert property (@(posedge clk) disable iff (rst)
    dev_rst_i |=> (pd_level_o == 2'd0 && !wake_pulse_o)); // R10

  AST_RESERVED_NO_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (pd_level_o == 2'd0 && req_we_i && !code_known) |=> pd_level_o == 2'd0); // R5

endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk #(
  .WORD_W    (WORD_W),
  .FIELD_LSB (FIELD_LSB),
  .NUM_IRQ   (NUM_IRQ)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .dev_rst_i     (dev_rst_i),
  .req_we_i      (req_we_i),
  .req_code_i    (req_code_i),
  .csr_rd_i      (csr_rd_i),
  .csr_rd_o      (csr_rd_o),
  .irq_pend_i    (irq_pend_i),
  .irq_en_mask_i (irq_en_mask_i),
  .cpu_halt_o    (cpu_halt_o),
  .pd_level_o    (pd_level_o),
  .wake_pulse_o  (wake_pulse_o)
);

// File: tb/pwrdn_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwrdn_ctrl_tb_top;

  localparam int WORD_W  = 32;
  localparam int NUM_IRQ = 8;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               dev_rst_i = 1'b0;
  logic               req_we_i = 1'b0;
  logic [5:0]         req_code_i = '0;
  logic [WORD_W-1:0]  csr_rd_i = '0;
  logic [WORD_W-1:0]  csr_rd_o;
  logic [NUM_IRQ-1:0] irq_pend_i = '0;
  logic [NUM_IRQ-1:0] irq_en_mask_i = '0;
  logic               cpu_halt_o;
  logic [1:0]         pd_level_o;
  logic               wake_pulse_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  pwrdn_ctrl #(.WORD_W(WORD_W), .FIELD_LSB(10), .NUM_IRQ(NUM_IRQ)) dut_i (
    .clk(clk), .rst(rst), .dev_rst_i(dev_rst_i), .req_we_i(req_we_i),
    .req_code_i(req_code_i), .csr_rd_i(csr_rd_i), .csr_rd_o(csr_rd_o),
    .irq_pend_i(irq_pend_i), .irq_en_mask_i(irq_en_mask_i),
    .cpu_halt_o(cpu_halt_o), .pd_level_o(pd_level_o), .wake_pulse_o(wake_pulse_o)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // R2..R5: level the request code selects
  function automatic int exp_level(input logic [5:0] c);
    case (c)
      6'b001001, 6'b010001: return 1;
      6'b011010:            return 2;
      6'b011100:            return 3;
      default:              return 0;
    endcase
  endfunction

  function automatic string lvl_tag(input logic [5:0] c);
    case (c)
      6'b001001: return "R2";
      6'b010001: return "R3";
      6'b011010, 6'b011100: return "R4";
      default:   return "R5";
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check_state(input string tag, input int lvl, input int wk);
    chk(tag, "level", pd_level_o, lvl);
    chk("R12", "halt", cpu_halt_o, (lvl != 0));
    chk(tag, "wake", wake_pulse_o, wk);
  endtask

  task automatic write_code(input logic [5:0] c);
    req_we_i = 1'b1; req_code_i = c;
    step();
    req_we_i = 1'b0; req_code_i = '0;
  endtask

  task automatic pulse_irq(input logic [NUM_IRQ-1:0] p, input logic [NUM_IRQ-1:0] m);
    irq_pend_i = p; irq_en_mask_i = m;
    step();
    irq_pend_i = '0; irq_en_mask_i = '0;
  endtask

  task automatic pulse_dev_rst();
    dev_rst_i = 1'b1;
    step();
    dev_rst_i = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    check_state("R1", 0, 0);

    for (int c = 0; c < 64; c++) begin
      logic [5:0] code = 6'(c);
      int lv = exp_level(code);
      logic [WORD_W-1:0] pat = {code, ~code, code, 2'b10, code, ~code} ^ WORD_W'(c * 32'h9E37);

      csr_rd_i = pat;
      #0.5;
      chk("R6", "readback", csr_rd_o, pat & ~(WORD_W'(6'h3F) << 10));

      write_code(code);
      check_state(lvl_tag(code), lv, 0);

      if (lv != 0) begin
        write_code(code == 6'b011100 ? 6'b001001 : 6'b011100);
        check_state("R11", lv, 0);

        pulse_irq(8'h10, 8'h00);
        if (code == 6'b010001) begin
          check_state("R3", 0, 1);
        end else begin
          check_state(lv == 1 ? "R8" : "R9", lv, 0);
          pulse_irq(8'h24, 8'h04);
          if (lv == 1) check_state("R7", 0, 1);
          else         check_state("R9", lv, 0);
        end
        step();
        chk("R7", "wake after pulse", wake_pulse_o, 0);
      end

      pulse_dev_rst();
      check_state("R10", 0, 0);
    end

    // Collision: device reset with a request write while running
    req_we_i = 1'b1; req_code_i = 6'b011010; dev_rst_i = 1'b1;
    step();
    req_we_i = 1'b0; dev_rst_i = 1'b0;
    check_state("R10", 0, 0);

    // Collision: device reset with a qualifying interrupt at level 1
    write_code(6'b001001);
    check_state("R2", 1, 0);
    irq_pend_i = 8'hFF; irq_en_mask_i = 8'hFF; dev_rst_i = 1'b1;
    step();
    irq_pend_i = '0; irq_en_mask_i = '0; dev_rst_i = 1'b0;
    check_state("R10", 0, 0);

    // Device reset out of the deepest level after idle cycles
    write_code(6'b011100);
    repeat (5) step();
    check_state("R9", 3, 0);
    pulse_dev_rst();
    check_state("R10", 0, 0);

    // Block reset in the middle of a sleep
    write_code(6'b011010);
    rst = 1'b1;
    step();
    rst = 1'b0;
    check_state("R1", 0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule